// File: doc/BRIEF.md
# Iterative Bitsliced Block Decryptor

This block recovers a 128-bit plaintext block from a ciphertext block produced by a 32-round, four-word bitsliced substitution-permutation cipher. It performs one round per clock. The state is held as four 32-bit words, and each bit position across the four words forms one 4-bit nibble that goes through a substitution box. Round keys are not stored inside the block. A key request port presents a round index, and the surrounding logic returns the matching 128-bit subkey in the same cycle.

A transfer begins when `start` is high while `ready` is high. The block consumes subkey 32 in that cycle. It then runs 32 busy cycles that request subkeys 31 down to 0 and unwinds one round in each. At the end it raises `done` for one cycle. The recovered block stays on `pt_out` until the next accepted start.

Top module: `bsd_core`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, `pt_out` is all zeros and `key_idx` is 32.
- R2: A `start` seen while `ready` is 1 is accepted at that clock edge. `ready` then stays 0 for exactly 32 cycles. `done` is high for exactly one cycle, on the cycle after the 32nd busy edge, and `ready` returns to 1 in that same cycle.
- R3: While idle, `key_idx` shows 32. In the busy cycles that follow acceptance it shows 31, 30, ... 0, stepping down by one each cycle.
- R4: The inverse substitution used when unwinding round r is box number r mod 8. For bit i, the nibble is {w3[i], w2[i], w1[i], w0[i]}, with w0 as the least significant bit. The box mappings for inputs 0..15 are:
  - box 0: 13 3 11 0 10 6 5 12 1 14 4 7 15 9 8 2
  - box 1: 5 8 2 14 15 6 12 3 11 4 7 9 1 13 10 0
  - box 2: 12 9 15 4 11 14 1 2 0 3 6 13 5 8 10 7
  - box 3: 0 9 10 7 11 14 6 13 3 5 12 2 4 8 15 1
  - box 4: 5 0 8 3 10 9 7 14 2 12 11 6 4 15 13 1
  - box 5: 8 15 2 9 4 1 13 14 11 6 5 3 7 12 10 0
  - box 6: 15 10 1 13 5 3 6 0 4 9 14 7 2 12 8 11
  - box 7: 3 0 6 13 9 14 15 8 5 12 11 7 10 1 4 2
- R5: The inverse diffusion is applied before the substitution in rounds 30..0 and skipped in round 31. It runs in this order:
  1. Rotate w0 right by 5 and w2 right by 22.
  2. Set w0 ^= w1 ^ w3 and w2 ^= w3 ^ (w1 << 7), using the unrotated w1 and w3.
  3. Rotate w1 right by 1 and w3 right by 7.
  4. Set w1 ^= w0 ^ w2 and w3 ^= w2 ^ (w0 << 3).
  5. Rotate w0 right by 13 and w2 right by 3.
- R6: Key mixing XORs subkey word j into state word j. Word j of `ct_in`, `key_in` and `pt_out` occupies bits [32j+31:32j].
- R7: For any subkeys K0..K32 and any plaintext P, decrypting the ciphertext of P yields P exactly. The ciphertext is formed by applying, for r = 0..31: XOR with Kr, forward box r mod 8, then forward diffusion for r < 31. The final step is an XOR with K32.
- R8: A `start` (with any `ct_in`) arriving while busy is ignored and does not change the result or the key index sequence.
- R9: `pt_out` holds its value from `done` until the next accepted start.
- R10: Each inverse box composed with its forward box is the identity on all 16 inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin decrypting `ct_in` |
| ready | output | 1 | High when idle and able to accept `start` |
| ct_in | input | 128 | Ciphertext block, word j at bits [32j+31:32j] |
| key_idx | output | 6 | Index of the subkey requested this cycle |
| key_in | input | 128 | Subkey for `key_idx`, returned in the same cycle |
| pt_out | output | 128 | Recovered plaintext / working state |
| done | output | 1 | One-cycle pulse when `pt_out` is final |

## Verification
Taking the accepting edge as edge 0, the key index for round 31 is visible just after edge 0. The index for round 31-k is visible just after edge k, so `done` and the final `pt_out` appear just after edge 32. The bench drives and samples on falling edges. It checks the index at every one of the 32 following falling edges. It expects `done` exactly at the 33rd falling edge, and then confirms the output one cycle later, when `done` has dropped. The expected plaintext comes from the bench's own forward cipher model, with its own forward box tables, run under random subkeys.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 4;
  localparam int BLOCK_W  = WORD_W * NWORDS;
  localparam int NUM_BOXES = 8;
  localparam int BOX_W    = $clog2(NUM_BOXES);

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NWORDS-1:0] blk_t;   // blk[j] sits at bits [32j+31:32j]

  function automatic word_t ror(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // Packed inverse box contents: output for input n at bits [4n+3:4n]
  function automatic logic [63:0] inv_box_tab(input logic [BOX_W-1:0] box);
    case (box)
      3'd0:    return 64'h289F_74E1_C56A_0B3D;
      3'd1:    return 64'h0AD1_974B_3C6F_E285;
      3'd2:    return 64'h7A85_D630_21EB_4F9C;
      3'd3:    return 64'h1F84_2C53_D6EB_7A90;
      3'd4:    return 64'h1DF4_6BC2_E79A_3805;
      3'd5:    return 64'h0AC7_356B_ED14_92F8;
      3'd6:    return 64'hB8C2_7E94_0635_D1AF;
      default: return 64'h241A_7BC5_8FE9_D603;
    endcase
  endfunction

  function automatic logic [3:0] sbox_inv(input logic [BOX_W-1:0] box, input logic [3:0] nib);
    logic [63:0] tab;
    tab = inv_box_tab(box);
    return tab[{nib, 2'b00} +: 4];
  endfunction

  // Inverse diffusion, steps in the required order
  function automatic blk_t inv_lt(input blk_t x);
    word_t a, b, c, d;
    a = ror(x[0], 5);
    c = ror(x[2], 22);
    a = a ^ x[1] ^ x[3];
    c = c ^ x[3] ^ (x[1] << 7);
    b = ror(x[1], 1);
    d = ror(x[3], 7);
    b = b ^ a ^ c;
    d = d ^ c ^ (a << 3);
    a = ror(a, 13);
    c = ror(c, 3);
    return '{d, c, b, a};
  endfunction
endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl #(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             first_rnd,
  output logic             last_rnd,
  output logic [IDX_W-1:0] round,
  output logic             done
);
  localparam logic [IDX_W-1:0] TOP_RND = IDX_W'(ROUNDS - 1);

  assign accept    = start & ~busy;
  assign first_rnd = busy & (round == TOP_RND);
  assign last_rnd  = busy & (round == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      round <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_rnd;
      if (accept) begin
        busy  <= 1'b1;
        round <= TOP_RND;
      end else if (busy) begin
        if (round == '0) busy <= 1'b0;
        else             round <= round - 1'b1;
      end
    end
  end

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && round != '0 |=> busy && round == $past(round) - 1'b1); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && round != '0 |=> busy && round != TOP_RND); // R8
endmodule

// File: rtl/bsd_invlt.sv
module bsd_invlt
  import bsd_pkg::*;
(
  input  blk_t din,
  input  logic bypass,
  output blk_t dout
);
  blk_t mixed;
  assign mixed = inv_lt(din);
  assign dout  = bypass ? din : mixed;
endmodule

// File: rtl/bsd_sbox_layer.sv
module bsd_sbox_layer
  import bsd_pkg::*;
(
  input  blk_t             din,
  input  logic [BOX_W-1:0] box,
  output blk_t             dout
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_slice
    logic [3:0] nib_in, nib_out;
    assign nib_in = {din[3][i], din[2][i], din[1][i], din[0][i]};
    assign nib_out = sbox_inv(box, nib_in);
    assign dout[0][i] = nib_out[0];
    assign dout[1][i] = nib_out[1];
    assign dout[2][i] = nib_out[2];
    assign dout[3][i] = nib_out[3];
  end
endmodule

// File: rtl/bsd_core.sv
module bsd_core
  import bsd_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               ready,
  input  logic [BLOCK_W-1:0] ct_in,
  output logic [IDX_W-1:0]   key_idx,
  input  logic [BLOCK_W-1:0] key_in,
  output logic [BLOCK_W-1:0] pt_out,
  output logic               done
);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(ROUNDS);

  logic             accept, busy, first_rnd, last_rnd;
  logic [IDX_W-1:0] round;
  blk_t             state, lt_out, sb_out, key_blk;

  bsd_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .first_rnd(first_rnd), .last_rnd(last_rnd), .round(round), .done(done)
  );

  bsd_invlt u_lt (.din(state), .bypass(first_rnd), .dout(lt_out));

  bsd_sbox_layer u_sb (.din(lt_out), .box(round[BOX_W-1:0]), .dout(sb_out));

  assign key_blk = blk_t'(key_in);
  assign key_idx = busy ? round : IDLE_IDX;
  assign ready   = ~busy;
  assign pt_out  = BLOCK_W'(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= '0;
    else if (accept) state <= blk_t'(ct_in) ^ key_blk;
    else if (busy)   state <= sb_out ^ key_blk;
  end

  AST_IDLE_KEY_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> key_idx == IDLE_IDX); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start |=> $stable(pt_out)); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R2
endmodule

// File: tb/bsd_core_bench.sv
module bsd_core_bench;
  import bsd_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ready, done;
  logic [127:0] ct_in = '0;
  logic [5:0]   key_idx;
  logic [127:0] key_in, pt_out;
  logic [127:0] key_mem [0:32];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign key_in = (key_idx <= 6'd32) ? key_mem[key_idx] : '0;

  bsd_core u_bsd_core (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .ct_in(ct_in),
    .key_idx(key_idx), .key_in(key_in), .pt_out(pt_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Forward model, written independently of the design
  function automatic logic [63:0] fwd_tab(input int b);
    case (b)
      0: return 64'hC907_24DE_B56A_1F83;
      1: return 64'h43D6_8EB1_A509_72CF;
      2: return 64'h25B0_4E1D_FAC3_9768;
      3: return 64'hE57A_421D_369C_8BF0;
      4: return 64'hD7E9_A452_6B0C_38F1;
      5: return 64'h176D_8E30_C9A4_B25F;
      6: return 64'h0A3D_F19E_B648_5C27;
      default: return 64'h6539_AC47_B28E_0FD1;
    endcase
  endfunction

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] fwd_round(input logic [127:0] s, input int r, input bit diffuse);
    logic [31:0] w0, w1, w2, w3, o0, o1, o2, o3;
    logic [63:0] t;
    t = fwd_tab(r % 8);
    {w3, w2, w1, w0} = s;
    for (int i = 0; i < 32; i++) begin
      logic [3:0] n, q;
      n = {w3[i], w2[i], w1[i], w0[i]};
      q = t[4*n +: 4];
      o0[i] = q[0]; o1[i] = q[1]; o2[i] = q[2]; o3[i] = q[3];
    end
    if (diffuse) begin
      o0 = rol(o0, 13); o2 = rol(o2, 3);
      o1 = o1 ^ o0 ^ o2; o3 = o3 ^ o2 ^ (o0 << 3);
      o1 = rol(o1, 1); o3 = rol(o3, 7);
      o0 = o0 ^ o1 ^ o3; o2 = o2 ^ o3 ^ (o1 << 7);
      o0 = rol(o0, 5); o2 = rol(o2, 22);
    end
    return {o3, o2, o1, o0};
  endfunction

  function automatic logic [127:0] encrypt(input logic [127:0] p);
    logic [127:0] s;
    s = p;
    for (int r = 0; r < 32; r++) s = fwd_round(s ^ key_mem[r], r, r < 31);
    return s ^ key_mem[32];
  endfunction

  task automatic load_keys(input bit zero);
    for (int k = 0; k <= 32; k++)
      key_mem[k] = zero ? '0 : {$urandom, $urandom, $urandom, $urandom};
  endtask

  // One decryption; optional stray start while busy (R8)
  task automatic run_one(input logic [127:0] p, input bit stray, input string tag);
    logic [127:0] c;
    c = encrypt(p);
    @(negedge clk);
    check(ready == 1'b1, "R2 ready before start", 128'(ready), 128'd1);
    ct_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; ct_in = ~c;
    check(ready == 1'b0, "R2 ready drops", 128'(ready), 128'd0);
    check(key_idx == 6'd31, "R3 first index", 128'(key_idx), 128'd31);
    for (int k = 2; k <= 32; k++) begin
      if (stray && k == 10) begin start = 1'b1; ct_in = {$urandom, $urandom, $urandom, $urandom}; end
      if (stray && k == 14) start = 1'b0;
      @(negedge clk);
      check(key_idx == 6'(32 - k), "R3 index step", 128'(key_idx), 128'(32 - k));
      check(done == 1'b0 && ready == 1'b0, "R2 busy window", 128'({done, ready}), 128'd0);
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R2 done timing", 128'(done), 128'd1);
    check(ready == 1'b1 && key_idx == 6'd32, "R3 idle index", 128'(key_idx), 128'd32);
    check(pt_out == p, {"R7 R6 R4 R5 plaintext ", tag}, pt_out, p);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", 128'(done), 128'd0);
    check(pt_out == p, "R9 output holds", pt_out, p);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R1 ready", 128'(ready), 128'd1);
    check(done == 1'b0, "R1 done", 128'(done), 128'd0);
    check(pt_out == '0, "R1 pt_out", pt_out, '0);
    check(key_idx == 6'd32, "R1 key_idx", 128'(key_idx), 128'd32);
  endtask

  task automatic t_box_identity();
    for (int b = 0; b < 8; b++) begin
      bit ok;
      logic [63:0] t;
      ok = 1'b1;
      t = fwd_tab(b);
      for (int n = 0; n < 16; n++)
        if (sbox_inv(3'(b), t[4*n +: 4]) != 4'(n)) ok = 1'b0;
      check(ok, "R10 inverse of forward box", 128'(b), 128'(b));
    end
  endtask

  task automatic t_zero();
    load_keys(1'b1);
    run_one('0, 1'b0, "zero key zero data");
    run_one({32'h0, 32'h0, 32'h0, 32'h1}, 1'b0, "single bit");
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++) begin
      load_keys(1'b0);
      run_one({$urandom, $urandom, $urandom, $urandom}, 1'b0, "random");
    end
  endtask

  task automatic t_stray_start();
    load_keys(1'b0);
    run_one({$urandom, $urandom, $urandom, $urandom}, 1'b1, "R8 stray start");
  endtask

  task automatic t_hold();
    logic [127:0] keep;
    keep = pt_out;
    ct_in = '1;
    repeat (5) @(negedge clk);
    check(pt_out == keep, "R9 idle hold", pt_out, keep);
  endtask

  initial begin
    load_keys(1'b1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_box_identity();
    t_zero();
    t_random();
    t_stray_start();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule